// File: doc/BRIEF.md
# DSP Register Load/Store Formatter

This block holds the operand registers of a DSP unit and formats single transfers between them and a 32-bit memory data bus. There are two accumulators, each a 32-bit main part plus an 8-bit guard extension, and a parameterised number of plain 32-bit registers. A transfer request names one register, says whether it is a load or a store, and gives the size: word or longword.

Loads take data from the bus and commit it into the named register on the clock edge. A word goes into the upper half, and the lower half is cleared. A load into an accumulator also refills its guard field with the sign of the new value. Each guard field can be named as a register of its own, for loading or for storing. A guard store sign-extends the 8 bits across the full bus width.

Stores are combinational, so the formatted value is on the bus in the same cycle as the request. A request that names the DSP status register, or any unassigned code, is refused. A refused request raises an error flag and touches nothing.

Top module: `dsp_xfer_regfile`

## Requirements
- R1: After reset every accumulator main part, every guard field and every plain register reads as zero.
- R2: Register select codes are 0 and 1 for the accumulator main parts, 2 and 3 for guard fields 0 and 1, and 4 to 4+NPLAIN-1 for the plain registers. Code 15 is the status register.
- R3: A longword load (`xfer_long`=1) writes `load_data[31:0]` unchanged into the selected accumulator or plain register at the clock edge where `xfer_valid` is high.
- R4: A word load (`xfer_long`=0) writes `load_data[15:0]` into bits 31:16 of the selected accumulator or plain register and clears bits 15:0.
- R5: An accumulator load of either size sets all 8 guard bits of that accumulator to bit 31 of the value written.
- R6: A load naming a guard field (code 2 or 3) writes `load_data[7:0]` into that guard field only, whatever the size. The accumulator main part and every other register are left unchanged.
- R7: A longword store drives all 32 bits of the selected accumulator or plain register on `store_data`.
- R8: A word store drives bits 31:16 of the selected register on `store_data[15:0]` and zero on `store_data[31:16]`.
- R9: A guard store drives the 8 guard bits on `store_data[7:0]` and copies guard bit 7 into `store_data[31:8]`, whatever the size.
- R10: A request with code 15 or any unassigned code raises `xfer_err` in the same cycle. It writes no register and drives zero on `store_data`.
- R11: `store_data` reflects a store request combinationally in the same cycle. It is zero whenever no valid store is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | Transfer request strobe |
| xfer_store | input | 1 | 1 = store (register to bus), 0 = load |
| xfer_long | input | 1 | 1 = longword, 0 = word |
| xfer_sel | input | 4 | Register select code |
| load_data | input | 32 | Data from memory for loads |
| store_data | output | 32 | Formatted register contents for stores |
| xfer_err | output | 1 | Request names the status register or an unassigned code |

## Verification
The bench goes after the sign boundary. It loads values whose bit 31 or guard bit 7 flips between consecutive transfers. A design that took the guard sign from the wrong bit, or from a word datum before placement, would leave stale or inverted guard bits. A design that sign-extended the wrong way would show them on a guard store.

Word transfers use patterns with nonzero low halves. A design that kept the old low half, or placed the word in the wrong half on the bus, mismatches at once. Guard-only loads are followed by main-part stores, so a design that spilled the guard write into the accumulator is caught. Refused codes are followed by stores of every register, so a design that wrote on a rejected request is caught.

// File: rtl/dsp_xfer_regfile.sv
module dsp_xfer_regfile #(
  parameter int DW     = 32,
  parameter int GW     = 8,
  parameter int NPLAIN = 6,
  parameter int SELW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_valid,
  input  logic            xfer_store,
  input  logic            xfer_long,
  input  logic [SELW-1:0] xfer_sel,
  input  logic [DW-1:0]   load_data,
  output logic [DW-1:0]   store_data,
  output logic            xfer_err
);

  localparam int HW          = DW / 2;
  localparam int NACC        = 2;
  localparam int GRD_BASE    = NACC;
  localparam int PLAIN_BASE  = 2 * NACC;
  localparam int PLAIN_END   = PLAIN_BASE + NPLAIN;

  logic [DW-1:0] acc_m   [NACC];
  logic [GW-1:0] acc_g   [NACC];
  logic [DW-1:0] plain_q [NPLAIN];

  logic          is_acc, is_grd, is_plain, sel_ok, wr_en;
  logic [DW-1:0] load_main;
  logic [GW-1:0] load_ext;
  logic [DW-1:0] rd_main;
  logic [GW-1:0] rd_grd;
  logic [DW-1:0] fmt;

  assign is_acc   = int'(xfer_sel) < NACC;
  assign is_grd   = int'(xfer_sel) >= GRD_BASE && int'(xfer_sel) < PLAIN_BASE;
  assign is_plain = int'(xfer_sel) >= PLAIN_BASE && int'(xfer_sel) < PLAIN_END;
  assign sel_ok   = is_acc | is_grd | is_plain;
  assign xfer_err = xfer_valid & ~sel_ok;
  assign wr_en    = xfer_valid & ~xfer_store & sel_ok;

  assign load_main = xfer_long ? load_data : {load_data[HW-1:0], {HW{1'b0}}};
  assign load_ext  = {GW{load_main[DW-1]}};

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_m[i] <= '0;
        acc_g[i] <= '0;
      end else if (wr_en && int'(xfer_sel) == i) begin
        acc_m[i] <= load_main;
        acc_g[i] <= load_ext;
      end else if (wr_en && int'(xfer_sel) == GRD_BASE + i) begin
        acc_g[i] <= load_data[GW-1:0];
      end
    end
  end

  for (genvar j = 0; j < NPLAIN; j++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        plain_q[j] <= '0;
      else if (wr_en && int'(xfer_sel) == PLAIN_BASE + j)
        plain_q[j] <= load_main;
    end
  end

  always_comb begin
    rd_main = '0;
    rd_grd  = '0;
    for (int i = 0; i < NACC; i++) begin
      if (int'(xfer_sel) == i)            rd_main = acc_m[i];
      if (int'(xfer_sel) == GRD_BASE + i) rd_grd  = acc_g[i];
    end
    for (int j = 0; j < NPLAIN; j++)
      if (int'(xfer_sel) == PLAIN_BASE + j) rd_main = plain_q[j];
  end

  always_comb begin
    if (is_grd)
      fmt = {{(DW-GW){rd_grd[GW-1]}}, rd_grd};
    else if (xfer_long)
      fmt = rd_main;
    else
      fmt = {{HW{1'b0}}, rd_main[DW-1:HW]};
  end

  assign store_data = (xfer_valid && xfer_store && sel_ok) ? fmt : '0;

endmodule

module dsp_xfer_regfile_chk #(
  parameter int DW   = 32,
  parameter int GW   = 8,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xfer_valid,
  input logic            xfer_store,
  input logic            xfer_long,
  input logic [SELW-1:0] xfer_sel,
  input logic [DW-1:0]   store_data,
  input logic            xfer_err,
  input logic [DW-1:0]   acc0_main,
  input logic [GW-1:0]   acc0_guard
);

  // R10
  status_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_sel == '1) |-> (xfer_err && store_data == '0));

  // R10
  reject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_store && xfer_err) |=> ($stable(acc0_main) && $stable(acc0_guard)));

  // R9
  guard_store_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_store && (xfer_sel == 2 || xfer_sel == 3))
      |-> store_data[DW-1:GW] == {(DW-GW){store_data[GW-1]}});

  // R8
  word_store_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_store && !xfer_long && xfer_sel != 2 && xfer_sel != 3)
      |-> store_data[DW-1:DW/2] == '0);

  // R11
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_valid && xfer_store) |-> store_data == '0);

  // R5
  acc_guard_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_store && xfer_sel == 0) |=> acc0_guard == {GW{acc0_main[DW-1]}});

  // R4
  word_load_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_store && !xfer_long && xfer_sel == 0) |=> acc0_main[DW/2-1:0] == '0);

  // R6
  guard_load_main_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_store && xfer_sel == 2) |=> $stable(acc0_main));

endmodule

bind dsp_xfer_regfile dsp_xfer_regfile_chk #(.DW(DW), .GW(GW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_store(xfer_store),
  .xfer_long(xfer_long), .xfer_sel(xfer_sel), .store_data(store_data),
  .xfer_err(xfer_err), .acc0_main(acc_m[0]), .acc0_guard(acc_g[0])
);

// File: tb/dsp_xfer_regfile_tb.sv
module dsp_xfer_regfile_tb;

  localparam int NP = 6;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        xfer_valid = 0, xfer_store = 0, xfer_long = 0;
  logic [3:0]  xfer_sel = 0;
  logic [31:0] load_data = 0;
  logic [31:0] store_data;
  logic        xfer_err;

  int checks = 0, fails = 0;
  logic [31:0] mm [2+NP];
  logic [7:0]  mg [2];

  always #10 clk = ~clk;

  dsp_xfer_regfile #(.NPLAIN(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_store(xfer_store),
    .xfer_long(xfer_long), .xfer_sel(xfer_sel), .load_data(load_data),
    .store_data(store_data), .xfer_err(xfer_err)
  );

  function automatic int midx(logic [3:0] s);
    return (s < 2) ? int'(s) : int'(s) - 2;
  endfunction

  function automatic bit sel_valid(logic [3:0] s);
    return int'(s) < 4 + NP;
  endfunction

  function automatic logic [31:0] exp_store(logic [3:0] s, logic lng);
    if (!sel_valid(s)) return 32'h0;
    if (s == 2 || s == 3) return {{24{mg[s-2][7]}}, mg[s-2]};
    return lng ? mm[midx(s)] : {16'h0, mm[midx(s)][31:16]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(logic st, logic lng, logic [3:0] s, logic [31:0] d, string req);
    logic [31:0] v;
    @(negedge clk);
    xfer_valid = 1; xfer_store = st; xfer_long = lng; xfer_sel = s; load_data = d;
    #2;
    chk({req, " err"}, {31'h0, xfer_err}, {31'h0, !sel_valid(s)});
    chk({req, " bus"}, store_data, st ? exp_store(s, lng) : 32'h0);
    @(posedge clk);
    if (!st && sel_valid(s)) begin
      v = lng ? d : {d[15:0], 16'h0};
      if (s == 2 || s == 3) mg[s-2] = d[7:0];
      else begin
        mm[midx(s)] = v;
        if (s < 2) mg[s] = {8{v[31]}};
      end
    end
    #1 xfer_valid = 0;
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < 4 + NP; s++) begin
      op(1, 1, 4'(s), 32'h0, req);
      op(1, 0, 4'(s), 32'h0, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0721));
    for (int i = 0; i < 2 + NP; i++) mm[i] = 0;
    mg[0] = 0; mg[1] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    sweep("R1");
    // R11 idle bus
    @(negedge clk); #2; chk("R11 idle", store_data, 32'h0);
    // R3 R5 longword load with negative sign
    op(0, 1, 0, 32'h8123_4567, "R3");
    op(1, 1, 0, 0, "R3");
    op(1, 0, 2, 0, "R5 neg");
    // R4 R5 word load positive, low half cleared
    op(0, 0, 0, 32'hFFFF_1234, "R4");
    op(1, 1, 0, 0, "R4");
    op(1, 1, 2, 0, "R5 pos");
    // R6 guard-only load leaves main part
    op(0, 1, 3, 32'h1234_56A5, "R6");
    op(0, 0, 2, 32'h0000_0080, "R6");
    op(1, 1, 0, 0, "R6 main kept");
    op(1, 1, 2, 0, "R9 neg guard");
    op(1, 0, 3, 0, "R9 guard word size");
    // R8 word store, R7 long store on plain
    op(0, 1, 4, 32'hCAFE_F00D, "R7");
    op(1, 0, 4, 0, "R8");
    op(1, 1, 4, 0, "R7");
    op(0, 0, 9, 32'h0000_8001, "R4 plain");
    op(1, 1, 9, 0, "R4 plain");
    // R10 rejected codes
    op(0, 1, 15, 32'hFFFF_FFFF, "R10 status");
    op(1, 1, 15, 0, "R10 status store");
    op(0, 1, 10, 32'hFFFF_FFFF, "R10 unassigned");
    sweep("R10 no write");
    // R2 random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] s;
      s = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(10, 15)) : 4'($urandom_range(0, 9));
      op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), s, $urandom, "R2 random");
    end
    sweep("R2 final");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule